// File: doc/BRIEF.md
# Station-Reading Frequency Meter

This block measures the frequency of a receiver's local oscillator and reports the frequency of the station the receiver is tuned to. Before each measurement window, a BCD count register is loaded with a selectable intermediate-frequency offset. The offset can be added or taken away. The register then counts rising edges of the input signal for a fixed window of reference-clock cycles, and the final value is latched for a display.

An optional decimal prescaler divides the input by 10 or 100 before counting. This keeps the counted rate low. The prescaler changes only where the display places its megahertz point, and the offset preload is scaled by the same ratio. A negative offset is applied by preloading the ten's complement into a register that has one guard digit more than the display. The borrow out of that guard digit is discarded.

The input passes through a two-flop synchroniser and an edge detector in the reference clock domain. The counted rate must therefore stay below half the reference clock. With the default `GATE_CYC` and a 250 MHz reference, the window lasts one second, so the count reads directly in hertz.

Top module: `lo_freq_meter`

## Requirements
- R1: After reset, `valid` stays low, `digits` is zero and `range_err` is low until the first full window has been measured. That result appears no earlier than `GATE_CYC` cycles after reset.
- R2: `valid` is a one-cycle pulse that repeats every `GATE_CYC` reference cycles. `digits`, `dp_pos` and `range_err` change only in the cycle where `valid` is high.
- R3: With no offset and no prescaling, the result equals the number of rising input edges in one window, to within one count. A still input gives exactly zero.
- R4: `pre_sel` selects the input division: 0 is divide by 1, 1 is divide by 10, and 2 or 3 is divide by 100.
- R5: `dp_pos` gives the position of the megahertz point, counted in digits from the right of `digits`. It is 6 for divide by 1, 5 for divide by 10 and 4 for divide by 100.
- R6: `off_sel` selects the offset: 0 or 3 is none, 1 is 455 kHz and 2 is 10.7 MHz. The count for the AM offset is 455000, 45500 or 4550, and for the FM offset 10700000, 1070000 or 107000, for divide by 1, 10 or 100. With `off_neg` low, this count is added to the result.
- R7: With `off_neg` high, the offset count is subtracted. The reported digits are the result modulo 10^8.
- R8: `range_err` is set with a result when the guard digit above the eight displayed digits is non-zero at the end of the window. This happens on overflow, or when a subtraction goes below zero.
- R9: `pre_sel`, `off_sel` and `off_neg` are sampled only at the start of a window. A change during a window has no effect on that window's result.
- R10: `digits` holds eight BCD digits. Digit k occupies bits 4k+3 to 4k, and digit 0 is the least significant.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock; also defines the window |
| rst_n | input | 1 | Active-low synchronous reset |
| sig_in | input | 1 | Signal whose rising edges are counted |
| pre_sel | input | 2 | Prescale selection |
| off_sel | input | 2 | Offset selection |
| off_neg | input | 1 | Subtract the offset when high |
| digits | output | 32 | Latched BCD result |
| dp_pos | output | 3 | Megahertz point position |
| range_err | output | 1 | Guard digit non-zero at end of window |
| valid | output | 1 | One-cycle strobe when a new result is latched |

## Verification
The guard-digit path is the hardest to reach from the ports. No short window can deliver enough edges to carry out of the eighth digit. Instead, the stimulus reaches it with a negative offset that is larger than the counted edges. The guard digit then stays at nine and the lower digits show the ten's complement, which checks the complement preload and the flag together. Sampling only at window start is exercised by changing the offset just after a strobe: the next result must still show the old setting and the one after it the new setting.

// File: rtl/lo_freq_meter.sv
module lo_freq_meter #(
  parameter int unsigned GATE_CYC = 250_000_000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sig_in,
  input  logic [1:0]  pre_sel,
  input  logic [1:0]  off_sel,
  input  logic        off_neg,
  output logic [31:0] digits,
  output logic [2:0]  dp_pos,
  output logic        range_err,
  output logic        valid
);
  localparam int ND = 9;
  localparam int CW = 4 * ND;
  localparam int GW = $clog2(GATE_CYC + 1);

  function automatic logic [CW-1:0] bcd_inc(input logic [CW-1:0] v);
    logic c;
    logic [3:0] d;
    c = 1'b1;
    for (int i = 0; i < ND; i++) begin
      d = v[4*i +: 4];
      if (c) begin
        if (d == 4'd9) d = 4'd0;
        else begin d = d + 4'd1; c = 1'b0; end
      end
      bcd_inc[4*i +: 4] = d;
    end
  endfunction

  function automatic logic [CW-1:0] tens_comp(input logic [CW-1:0] v);
    logic c;
    logic [4:0] d;
    c = 1'b1;
    for (int i = 0; i < ND; i++) begin
      d = 5'd9 - {1'b0, v[4*i +: 4]} + {4'd0, c};
      c = (d == 5'd10);
      tens_comp[4*i +: 4] = c ? 4'd0 : d[3:0];
    end
  endfunction

  logic [2:0]    sync;
  logic [GW-1:0] gate_cnt;
  logic [6:0]    pdiv;
  logic [1:0]    pre_q;
  logic          primed;
  logic [CW-1:0] cnt, cnt_n, off_bcd, preload;

  wire       edge_p = sync[1] & ~sync[2];
  wire [6:0] pmax   = (pre_q == 2'd0) ? 7'd0 : (pre_q == 2'd1) ? 7'd9 : 7'd99;
  wire       pulse  = edge_p && (pdiv == pmax);
  wire       term   = (gate_cnt == GW'(GATE_CYC - 1));

  always_comb begin
    off_bcd = '0;
    case (off_sel)
      2'd1: off_bcd = (pre_sel == 2'd0) ? 36'h000455000 :
                      (pre_sel == 2'd1) ? 36'h000045500 : 36'h000004550;
      2'd2: off_bcd = (pre_sel == 2'd0) ? 36'h010700000 :
                      (pre_sel == 2'd1) ? 36'h001070000 : 36'h000107000;
      default: off_bcd = '0;
    endcase
  end

  assign preload = off_neg ? tens_comp(off_bcd) : off_bcd;
  assign cnt_n   = pulse ? bcd_inc(cnt) : cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync      <= '0;
      gate_cnt  <= GW'(GATE_CYC - 1);
      pdiv      <= '0;
      pre_q     <= '0;
      primed    <= 1'b0;
      cnt       <= '0;
      digits    <= '0;
      dp_pos    <= 3'd6;
      range_err <= 1'b0;
      valid     <= 1'b0;
    end else begin
      sync  <= {sync[1:0], sig_in};
      valid <= 1'b0;
      if (term) begin
        gate_cnt <= '0;
        cnt      <= preload;
        pdiv     <= '0;
        pre_q    <= pre_sel;
        primed   <= 1'b1;
        if (primed) begin
          valid     <= 1'b1;
          digits    <= cnt_n[31:0];
          range_err <= (cnt_n[CW-1:32] != 4'd0);
          dp_pos    <= (pre_q == 2'd0) ? 3'd6 : (pre_q == 2'd1) ? 3'd5 : 3'd4;
        end
      end else begin
        gate_cnt <= gate_cnt + 1'b1;
        cnt      <= cnt_n;
        if (edge_p) pdiv <= (pdiv == pmax) ? 7'd0 : pdiv + 7'd1;
      end
    end
  end

  logic bcd_bad;
  always_comb begin
    bcd_bad = 1'b0;
    for (int i = 0; i < 8; i++) if (digits[4*i +: 4] > 4'd9) bcd_bad = 1'b1;
  end

  p_valid_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> !valid);
  p_result_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |-> ($stable(digits) && $stable(range_err) && $stable(dp_pos)));
  p_dp_legal_r5: assert property (@(posedge clk) disable iff (!rst_n)
    dp_pos inside {3'd4, 3'd5, 3'd6});
  p_digits_bcd_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !bcd_bad);
  p_valid_after_term_r1: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> (gate_cnt == '0 && primed));
endmodule

// File: tb/lo_freq_meter_tb.sv
`timescale 1ns/1ps
module lo_freq_meter_tb_top;
  localparam int W = 400;
  logic clk = 1'b0, rst_n = 1'b0, sig_in = 1'b0;
  logic [1:0] pre_sel = 2'd0, off_sel = 2'd0;
  logic off_neg = 1'b0;
  logic [31:0] digits;
  logic [2:0] dp_pos;
  logic range_err, valid;
  int checks = 0, failures = 0, half = 0;

  lo_freq_meter #(.GATE_CYC(W)) dut_i (.clk(clk), .rst_n(rst_n), .sig_in(sig_in),
    .pre_sel(pre_sel), .off_sel(off_sel), .off_neg(off_neg),
    .digits(digits), .dp_pos(dp_pos), .range_err(range_err), .valid(valid));

  always #2 clk = ~clk;

  initial forever begin
    if (half == 0) begin sig_in = 1'b0; #4; end
    else begin #(half * 4); sig_in = ~sig_in; end
  end

  function automatic longint bcd2int(input logic [31:0] b);
    longint r = 0;
    for (int i = 7; i >= 0; i--) r = r * 10 + b[4*i +: 4];
    return r;
  endfunction

  task automatic chk(input string req, input longint got, input longint exp, input longint tol);
    longint d = got - exp;
    checks++;
    if (d > tol || d < -tol) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, got, exp);
    end
  endtask

  task automatic wait_valid();
    do begin @(posedge clk); #1; end while (!valid);
  endtask

  task automatic measure(input int h, input logic [1:0] p, input logic [1:0] o, input logic n);
    half = h; pre_sel = p; off_sel = o; off_neg = n;
    wait_valid();
    wait_valid();
  endtask

  task automatic t_reset();
    int seen = 0;
    rst_n = 1'b0;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    chk("R1 digits", bcd2int(digits), 0, 0);
    chk("R1 range_err", range_err, 0, 0);
    for (int i = 0; i < W - 2; i++) begin @(posedge clk); #1; if (valid) seen++; end
    chk("R1 early valid", seen, 0, 0);
  endtask

  task automatic t_period();
    int n = 0;
    wait_valid();
    do begin @(posedge clk); #1; n++; end while (!valid);
    chk("R2 strobe period", n, W, 0);
    @(posedge clk); #1;
    chk("R2 strobe width", valid, 0, 0);
  endtask

  task automatic t_plain();
    measure(2, 0, 0, 0); chk("R3 period 4", bcd2int(digits), 100, 1);
    chk("R5 dp div1", dp_pos, 6, 0);
    measure(4, 0, 0, 0); chk("R3 period 8", bcd2int(digits), 50, 1);
    measure(0, 0, 0, 0); chk("R3 still", bcd2int(digits), 0, 0);
  endtask

  task automatic t_prescale();
    measure(2, 1, 0, 0); chk("R4 div10", bcd2int(digits), 10, 1);
    chk("R5 dp div10", dp_pos, 5, 0);
    measure(2, 2, 0, 0); chk("R4 div100", bcd2int(digits), 1, 1);
    chk("R5 dp div100", dp_pos, 4, 0);
  endtask

  task automatic t_offset();
    measure(0, 0, 1, 0); chk("R10 AM bcd layout", digits, 32'h00455000, 0);
    measure(2, 0, 1, 0); chk("R6 AM div1", bcd2int(digits), 455100, 1);
    chk("R8 no flag", range_err, 0, 0);
    measure(2, 0, 2, 0); chk("R6 FM div1", bcd2int(digits), 10700100, 1);
    measure(2, 1, 2, 0); chk("R6 FM div10", bcd2int(digits), 1070010, 1);
    measure(2, 3, 1, 0); chk("R6 AM div100", bcd2int(digits), 4551, 1);
  endtask

  task automatic t_negative();
    measure(0, 0, 1, 1); chk("R7 AM neg still", bcd2int(digits), 99545000, 0);
    chk("R8 flag below zero", range_err, 1, 0);
    measure(2, 2, 2, 1); chk("R7 FM neg div100", bcd2int(digits), 99893001, 1);
    measure(2, 0, 0, 1); chk("R7 zero neg", bcd2int(digits), 100, 1);
    chk("R8 zero neg flag", range_err, 0, 0);
  endtask

  task automatic t_midwindow();
    measure(0, 0, 0, 0);
    off_sel = 2'd2;
    wait_valid(); chk("R9 change ignored", bcd2int(digits), 0, 0);
    wait_valid(); chk("R9 change applied", bcd2int(digits), 10700000, 0);
  endtask

  initial begin
    #(200000 * 4);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    t_reset();
    t_period();
    t_plain();
    t_prescale();
    t_offset();
    t_negative();
    t_midwindow();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule